// File: doc/BRIEF.md
# Sleep Wakeup Status and Recovery Controller

This block owns one control/status word and one recovery word on a small register bus, and sequences the device's exit from a low-power sleep state. Software arms up to three wakeup sources (RTC counter rollover, RTC match, periodic interrupt timer), picks a RAM retention setting and sets a sleep-enable bit. The block then raises a sleep request to the power logic.

When an armed source fires during sleep, the block records which sources fired in sticky write-one-to-clear flags and sets a sleep-recovered flag. While that flag is set, the pads are held in their safe state. The block then drives a system reset whose length depends on a fast-recovery bit. When the reset ends, the control fields are cleared, so the device restarts awake.

A 30-bit recovery pointer, the fast-recovery bit and the wakeup flags survive this exit reset. Software can use them to find its recovery routine and to learn why the device woke.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After power-on reset both register words read 0 and `sleep_req_o`, `sys_rst_o`, `pad_safe_o` and `ram_ret_sel_o` are 0.
- R2: Word 0 holds the wakeup enables in bits [2:0] (bit 0 rollover, bit 1 match, bit 2 timer), the RAM retention select in [9:8], sleep enable in bit 12, the wakeup flags in [18:16] (same source order) and the sleep-recovered flag in bit 24. Word 1 holds the recovery pointer in [31:2] and fast recovery in bit 0. All other bits read 0 and ignore writes. Addresses other than 0 and 1 read 0 and ignore writes. `ram_ret_sel_o` follows the select field.
- R3: While awake, a stored sleep-enable of 1 raises `sleep_req_o` on the following cycle.
- R4: During sleep, an event on a disabled source neither sets its flag nor ends sleep.
- R5: An enabled event during sleep sets the flag of every enabled source that fired in that cycle. Writing 1 to a flag bit clears it and writing 0 has no effect. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R6: The wakeup ends sleep and asserts `sys_rst_o` for exactly 1000 cycles when fast recovery is 0, or exactly 16 cycles when it is 1.
- R7: Wakeup events that arrive while `sys_rst_o` is asserted do not restart or extend the reset, and set no flag.
- R8: The wakeup sets the sleep-recovered flag. `pad_safe_o` stays high while that flag is set, and writing 1 to bit 24 clears it.
- R9: When the exit reset ends, the enables, the sleep enable and the RAM select clear to 0. The recovery pointer, the fast-recovery bit and the wakeup flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| wake_evt_i | input | 3 | Wakeup events: bit 0 rollover, bit 1 match, bit 2 timer |
| sleep_req_o | output | 1 | High while the device is asleep |
| ram_ret_sel_o | output | RAMSEL_W | RAM retention select |
| sys_rst_o | output | 1 | Sleep-exit reset |
| pad_safe_o | output | 1 | Pads held in safe state |

## Verification
The hardest case to reach from the ports is an enabled wakeup arriving partway through the exit reset. It is only visible because the enables are still set at that point and the reset length stays fixed. The stimulus waits 500 cycles into a long exit reset with the sources still armed, then fires all three events. The length is then measured at the ports.

The second hard case is a set and a clear of the same flag on one edge. It is produced by firing two sources in the very cycle that software writes ones to their flag bits.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_EXIT} slp_state_e;

  localparam int unsigned NUM_SRC    = 3;
  localparam int unsigned SRC_OVF    = 0;
  localparam int unsigned SRC_MATCH  = 1;
  localparam int unsigned SRC_PIT    = 2;

  // word 0 layout
  localparam int unsigned EN_LSB     = 0;
  localparam int unsigned RAMSEL_LSB = 8;
  localparam int unsigned SLPEN_BIT  = 12;
  localparam int unsigned FLAG_LSB   = 16;
  localparam int unsigned SLEEPF_BIT = 24;
  // word 1 layout
  localparam int unsigned FAST_BIT   = 0;
  localparam int unsigned PTR_LSB    = 2;
endpackage

// File: rtl/slp_wake_src.sv
module slp_wake_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic en_clr_i,
  input  logic flag_clr_i,
  input  logic event_i,
  input  logic wake_i,
  output logic en_o,
  output logic hit_o,
  output logic flag_o
);
  logic en_q, flag_q;

  assign hit_o  = event_i & en_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (en_clr_i) en_q <= 1'b0;
    else if (en_wr_i)  en_q <= en_wdata_i;
  end

  // hardware set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (wake_i && hit_o)    flag_q <= 1'b1;
    else if (flag_clr_i)         flag_q <= 1'b0;
  end

  a_r4_off_src_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !en_q) |=> !flag_q);

  a_r5_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && event_i && en_q) |=> flag_q);
endmodule

// File: rtl/slp_exit_seq.sv
module slp_exit_seq
  import slp_wake_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 1000,
  parameter int unsigned SHORT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_en_i,
  input  logic hit_any_i,
  input  logic fast_i,
  output logic asleep_o,
  output logic exit_start_o,
  output logic exit_rst_o,
  output logic exit_done_o
);
  localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  slp_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign asleep_o     = (state_q == ST_SLEEP);
  assign exit_rst_o   = (state_q == ST_EXIT);
  assign exit_start_o = asleep_o & hit_any_i;
  assign exit_done_o  = exit_rst_o & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN:   if (sleep_en_i) state_q <= ST_SLEEP;
        ST_SLEEP: if (hit_any_i) begin
          state_q <= ST_EXIT;
          cnt_q   <= fast_i ? CNT_W'(SHORT_CYC - 1) : CNT_W'(LONG_CYC - 1);
        end
        ST_EXIT:  if (cnt_q == '0) state_q <= ST_RUN;
                  else cnt_q <= cnt_q - 1'b1;
        default:  state_q <= ST_RUN;
      endcase
    end
  end

  // independent length measurement for the checks below
  logic [CNT_W:0] len_q;
  logic           fast_lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= '0;
      fast_lat_q <= 1'b0;
    end else begin
      len_q <= exit_rst_o ? len_q + 1'b1 : '0;
      if (exit_start_o) fast_lat_q <= fast_i;
    end
  end

  a_r3_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && sleep_en_i) |=> asleep_o);

  a_r6_r7_exit_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(exit_rst_o) |->
      ((32'($past(len_q)) + 32'd1) == (fast_lat_q ? 32'(SHORT_CYC) : 32'(LONG_CYC))));
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_wake_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned RAMSEL_W  = 2,
  parameter int unsigned LONG_CYC  = 1000,
  parameter int unsigned SHORT_CYC = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic [NUM_SRC-1:0]  wake_evt_i,
  output logic                sleep_req_o,
  output logic [RAMSEL_W-1:0] ram_ret_sel_o,
  output logic                sys_rst_o,
  output logic                pad_safe_o
);
  localparam int unsigned PTR_W = 32 - PTR_LSB;

  logic wr_ctrl, wr_rec;
  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_W'(0));
  assign wr_rec  = reg_wr_i && (reg_addr_i == ADDR_W'(1));

  logic                unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  logic                sleep_en_q, sleepf_q, fast_q;
  logic [RAMSEL_W-1:0] ram_sel_q;
  logic [PTR_W-1:0]    ptr_q;

  logic [NUM_SRC-1:0]  en_w, hit_w, flag_w;
  logic                exit_start, exit_done, asleep;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    slp_wake_src u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_wr_i    (wr_ctrl),
      .en_wdata_i (reg_wdata_i[EN_LSB+g]),
      .en_clr_i   (exit_done),
      .flag_clr_i (wr_ctrl & reg_wdata_i[FLAG_LSB+g]),
      .event_i    (wake_evt_i[g]),
      .wake_i     (exit_start),
      .en_o       (en_w[g]),
      .hit_o      (hit_w[g]),
      .flag_o     (flag_w[g])
    );
  end

  slp_exit_seq #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_en_i   (sleep_en_q),
    .hit_any_i    (|hit_w),
    .fast_i       (fast_q),
    .asleep_o     (asleep),
    .exit_start_o (exit_start),
    .exit_rst_o   (sys_rst_o),
    .exit_done_o  (exit_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_en_q <= 1'b0;
      ram_sel_q  <= '0;
    end else if (exit_done) begin
      sleep_en_q <= 1'b0;
      ram_sel_q  <= '0;
    end else if (wr_ctrl) begin
      sleep_en_q <= reg_wdata_i[SLPEN_BIT];
      ram_sel_q  <= reg_wdata_i[RAMSEL_LSB +: RAMSEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                sleepf_q <= 1'b0;
    else if (exit_start)                        sleepf_q <= 1'b1;
    else if (wr_ctrl && reg_wdata_i[SLEEPF_BIT]) sleepf_q <= 1'b0;
  end

  // survives the exit reset: cleared only by power-on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      fast_q <= 1'b0;
    end else if (wr_rec) begin
      ptr_q  <= reg_wdata_i[31:PTR_LSB];
      fast_q <= reg_wdata_i[FAST_BIT];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(0)) begin
      reg_rdata_o[EN_LSB +: NUM_SRC]       = en_w;
      reg_rdata_o[RAMSEL_LSB +: RAMSEL_W]  = ram_sel_q;
      reg_rdata_o[SLPEN_BIT]               = sleep_en_q;
      reg_rdata_o[FLAG_LSB +: NUM_SRC]     = flag_w;
      reg_rdata_o[SLEEPF_BIT]              = sleepf_q;
    end else if (reg_addr_i == ADDR_W'(1)) begin
      reg_rdata_o[31:PTR_LSB]              = ptr_q;
      reg_rdata_o[FAST_BIT]                = fast_q;
    end
  end

  assign sleep_req_o   = asleep;
  assign ram_ret_sel_o = ram_sel_q;
  assign pad_safe_o    = sleepf_q;

  a_r8_pads_safe_on_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_start |=> (pad_safe_o && sys_rst_o));

  a_r9_ctrl_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (ram_ret_sel_o == '0 && !sleep_en_q && en_w == '0));
endmodule

// File: tb/slp_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module slp_wake_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [2:0]  ev = '0;
  logic        sleep_req, sys_rst, pad_safe;
  logic [1:0]  ram_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  slp_wake_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .wake_evt_i(ev),
    .sleep_req_o(sleep_req), .ram_ret_sel_o(ram_sel),
    .sys_rst_o(sys_rst), .pad_safe_o(pad_safe)
  );

  // behavioural reference model
  logic [2:0]  m_en, m_flag;
  logic [1:0]  m_ram;
  logic        m_slpen, m_sleepf, m_fast;
  logic [29:0] m_ptr;
  int          m_st, m_rem;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_flag = 0; m_ram = 0; m_slpen = 0; m_sleepf = 0;
      m_fast = 0; m_ptr = 0; m_st = 0; m_rem = 0;
    end else begin : upd
      logic [2:0] hits;
      int         st0;
      logic       slp0, fast0;
      hits = ev & m_en; st0 = m_st; slp0 = m_slpen; fast0 = m_fast;
      if (wr && addr == 0) begin
        m_en = wd[2:0]; m_ram = wd[9:8]; m_slpen = wd[12];
        m_flag = m_flag & ~wd[18:16];
        if (wd[24]) m_sleepf = 0;
      end
      if (wr && addr == 1) begin
        m_ptr = wd[31:2]; m_fast = wd[0];
      end
      if (st0 == 0) begin
        if (slp0) m_st = 1;
      end else if (st0 == 1) begin
        if (hits != 0) begin
          m_flag = m_flag | hits; m_sleepf = 1; m_st = 2;
          m_rem = fast0 ? 16 : 1000;
        end
      end else begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_st = 0; m_en = 0; m_ram = 0; m_slpen = 0;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    logic [31:0] v;
    v = 0;
    if (a == 0) begin
      v[2:0] = m_en; v[9:8] = m_ram; v[12] = m_slpen;
      v[18:16] = m_flag; v[24] = m_sleepf;
    end else if (a == 1) begin
      v[31:2] = m_ptr; v[0] = m_fast;
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // cycle-by-cycle compare, away from the clock edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk("R2 rdata vs model", rdata, exp_rd(addr));
      chk("R3 sleep_req vs model", 32'(sleep_req), 32'(m_st == 1));
      chk("R6 sys_rst vs model", 32'(sys_rst), 32'(m_st == 2));
      chk("R8 pad_safe vs model", 32'(pad_safe), 32'(m_sleepf));
      chk("R9 ram_sel vs model", 32'(ram_sel), 32'(m_ram));
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wd = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
    addr = 0;
  endtask

  task automatic pulse(input logic [2:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = 0;
  endtask

  task automatic count_rst(output int n, input int inject_at);
    n = 0;
    while (sys_rst && n < 3000) begin
      n++;
      ev = (n == inject_at) ? 3'b111 : 3'b000;
      @(negedge clk);
    end
    ev = 0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 word0 after reset", 0, 32'h0);
    rd_chk("R1 word1 after reset", 1, 32'h0);
    chk("R1 outputs after reset", {28'h0, sleep_req, sys_rst, pad_safe, |ram_sel}, 32'h0);

    // R2 reserved bits ignored, field placement
    reg_wr(0, 32'hFFFF_EFFF);
    rd_chk("R2 word0 reserved ignored", 0, 32'h0000_0307);
    chk("R2 ram select output", 32'(ram_sel), 32'd3);
    reg_wr(1, 32'hABCD_1237);
    rd_chk("R2 word1 reserved ignored", 1, 32'hABCD_1235);
    reg_wr(2, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped reads zero", 2, 32'h0);
    rd_chk("R2 unmapped write ignored", 0, 32'h0000_0307);

    // long recovery, only rollover armed
    reg_wr(1, 32'hABCD_1234);
    reg_wr(0, 32'h0000_1301);
    @(negedge clk);
    chk("R3 sleep request raised", 32'(sleep_req), 32'd1);
    pulse(3'b110);
    chk("R4 disabled sources keep sleep", 32'(sleep_req), 32'd1);
    rd_chk("R4 disabled sources set no flag", 0, 32'h0000_1301);
    pulse(3'b001);
    chk("R8 pads safe on exit", 32'(pad_safe), 32'd1);
    count_rst(n, 500);
    chk("R6 R7 long reset length", n, 1000);
    rd_chk("R9 R5 word0 after exit", 0, 32'h0101_0000);
    rd_chk("R9 pointer kept", 1, 32'hABCD_1234);
    chk("R9 ram select cleared", 32'(ram_sel), 32'd0);
    chk("R8 pads still safe", 32'(pad_safe), 32'd1);

    reg_wr(0, 32'h0);
    rd_chk("R5 write zero keeps flags", 0, 32'h0101_0000);
    reg_wr(0, 32'h0100_0000);
    chk("R8 pads released", 32'(pad_safe), 32'd0);
    rd_chk("R8 sleep flag cleared", 0, 32'h0001_0000);
    reg_wr(0, 32'h0001_0000);
    rd_chk("R5 flag cleared by one", 0, 32'h0);

    // short recovery, set and clear on the same edge
    reg_wr(1, 32'hABCD_1235);
    reg_wr(0, 32'h0000_1007);
    @(negedge clk);
    ev = 3'b110; addr = 0; wd = 32'h0006_1007; wr = 1'b1;
    @(negedge clk);
    ev = 0; wr = 1'b0;
    count_rst(n, 0);
    chk("R6 short reset length", n, 16);
    rd_chk("R5 set wins over clear", 0, 32'h0106_0000);
    rd_chk("R9 fast bit kept", 1, 32'hABCD_1235);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule